// File: doc/BRIEF.md
# Flash and Torch Mode Controller

This block decides how an LED driver stage is used: whether the LED is dark, lit at torch level or lit at flash level, and whether the boost converter runs and regulates current or voltage. A register block supplies a 2-bit operating mode, a software start bit, a strobe-type select, a safety duration and a general-purpose duration. A camera module supplies a hardware strobe. A thermal sensor supplies a fault input, and a radio transmitter supplies a masking input. The block reports its result as a level code, regulation-mode flags, a one-cycle timeout pulse and two sticky status flags.

In flash mode a safety timer bounds how long the flash level is held. The timer counts millisecond ticks that a prescaler derives from the system clock. The strobe type decides how a trigger is handled. Level triggering holds the flash only while a trigger stays high. Edge triggering fires one flash of fixed length. In voltage mode the same counter serves as a general-purpose timeout timer. In torch mode an optional PWM gate dims the LED at a fixed frame rate.

Top module: `flash_mode_ctl`

## Requirements
- R1: After reset, `ledLevel` is 0 (off), `convOn`, `voltReg`, `timeoutPulse`, `swStartClr`, `toFlag` and `overTemp` are all 0.
- R2: `ledLevel` uses 0 for off, 1 for torch and 2 for flash. Mode 0 gives off with the converter stopped. Mode 1 gives torch. Mode 2 with no trigger gives torch. Mode 3 gives off with `voltReg`=1. `convOn` is 1 in every mode except mode 0.
- R3: In mode 2 with `edgeMode`=0, a rising edge of `strobeIn` or `swStart` gives flash level from the next cycle. The flash lasts while `strobeIn` or `swStart` stays high and the timer runs.
- R4: In level-triggered flash, the level returns to torch in the same cycle that both triggers are low. The timer stops and no timeout pulse follows.
- R5: A flash started at clock edge k holds flash level for exactly (`safetyCount`+1)×TICK_DIV cycles. The level then returns to torch, and `timeoutPulse` and `swStartClr` are high for exactly one cycle.
- R6: With `edgeMode`=1, a flash runs its full duration even when its trigger falls. Trigger edges that arrive during the flash are ignored.
- R7: In mode 3, a rising edge of `swStart` starts a timer of (`gpCount`+1)×TICK_DIV cycles. When it ends, `timeoutPulse` pulses and the sticky `toFlag` is set. A `statusRead` clears `toFlag`.
- R8: While `maskIn` is high, flash level is replaced by torch at once. The safety timer keeps counting, and its timeout falls in the same cycle as without masking.
- R9: While `thermFault` is high, `ledLevel` is 0, `convOn` and `voltReg` are 0, `modeClr` is 1 and any running timer stops. `overTemp` is set from the next cycle and stays set until a `statusRead` is seen with the fault low.
- R10: In mode 1 with `dimEn`=1, the LED is at torch level for the first (`dimDuty`+1)×PWM_PERIOD/8 cycles of each PWM_PERIOD-cycle frame and off for the rest. The frame starts in the cycle that dimming turns on.
- R11: When `hwVoltMode` is high, `voltReg` and `convOn` are 1 in every mode, and `ledLevel` is the same as with the input low.
- R12: In mode 1 the triggers have no effect: the level stays torch and no timeout pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Operating mode from the register block |
| hwVoltMode | input | 1 | Hardware request for voltage regulation |
| strobeIn | input | 1 | Hardware flash trigger |
| swStart | input | 1 | Software start bit |
| edgeMode | input | 1 | 1 selects edge-triggered flash, 0 selects level-triggered flash |
| maskIn | input | 1 | Flash masking request |
| thermFault | input | 1 | Over-temperature indication |
| statusRead | input | 1 | Readout strobe that clears the sticky flags |
| safetyCount | input | CNT_W | Flash duration in ticks, minus one |
| gpCount | input | CNT_W | General-purpose duration in ticks, minus one |
| dimEn | input | 1 | Enables PWM dimming |
| dimDuty | input | 3 | Dimming duty step |
| ledLevel | output | 2 | LED level: 0 off, 1 torch, 2 flash |
| voltReg | output | 1 | Converter regulates output voltage |
| convOn | output | 1 | Converter enabled |
| timeoutPulse | output | 1 | One-cycle pulse when a timer expires |
| swStartClr | output | 1 | Request to clear the software start bit |
| modeClr | output | 1 | Request to reset the mode field to 0 |
| toFlag | output | 1 | Sticky general-purpose timeout flag |
| overTemp | output | 1 | Sticky over-temperature flag |

## Verification
The in-RTL assertions check on every cycle the following properties:
- A thermal fault forces the output off.
- Masking never lets flash level through.
- A timeout pulse lasts a single cycle.
- Torch mode never produces a timeout.
- A running counter never grows.
- Level-triggered flash never appears without a high trigger.

Only the bench scenarios can show the exact flash and timer lengths. They also cover the stop on a falling trigger, the ignored retriggers, the unshifted timeout under masking, the PWM on/off pattern, and the set and clear order of the sticky flags.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;
  parameter int CNT_W = 4;

  typedef enum logic [1:0] {
    LVL_OFF   = 2'd0,
    LVL_TORCH = 2'd1,
    LVL_FLASH = 2'd2
  } ledLvl_e;

  typedef enum logic [1:0] {
    MODE_SHUT  = 2'd0,
    MODE_TORCH = 2'd1,
    MODE_FLASH = 2'd2,
    MODE_VOLT  = 2'd3
  } opMode_e;

  typedef struct packed {
    logic load;
    logic run;
  } tmrStrb_t;
endpackage

// File: rtl/flash_mode_dp.sv
module flash_mode_dp
  import flash_mode_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int PWM_PERIOD = 409836
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrb_t         strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             dimActive,
  input  logic [2:0]       dimDuty,
  output logic             expire,
  output logic             pwmGate
);
  localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PWM_W  = $clog2(PWM_PERIOD + 1);
  localparam int STEP   = PWM_PERIOD / 8;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [PWM_W-1:0] PWM_LAST = PWM_W'(PWM_PERIOD - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] remCnt;
  logic             tick;

  assign tick   = strb.run && (preCnt == PRE_LAST);
  assign expire = tick && (remCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      remCnt <= '0;
    end else if (strb.load) begin
      preCnt <= '0;
      remCnt <= loadVal;
    end else if (strb.run) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick && remCnt != '0) remCnt <= remCnt - 1'b1;
    end
  end

  // PWM dimming frame counter, restarted while dimming is inactive
  logic [PWM_W-1:0] pwmCnt;
  logic [PWM_W+3:0] onCycles;

  assign onCycles = (PWM_W + 4)'((dimDuty + 4'd1) * STEP);
  assign pwmGate  = ({4'd0, pwmCnt} < onCycles);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pwmCnt <= '0;
    else if (!dimActive)         pwmCnt <= '0;
    else if (pwmCnt == PWM_LAST) pwmCnt <= '0;
    else                         pwmCnt <= pwmCnt + 1'b1;
  end

  // R6: a running counter only ever counts down
  assert_rem_no_grow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.load) |=> (remCnt <= $past(remCnt)));

  // R10: the frame counter stays inside its period
  assert_pwm_in_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    pwmCnt <= PWM_LAST);
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             hwVoltMode,
  input  logic             strobeIn,
  input  logic             swStart,
  input  logic             edgeMode,
  input  logic             maskIn,
  input  logic             thermFault,
  input  logic             statusRead,
  input  logic [CNT_W-1:0] safetyCount,
  input  logic [CNT_W-1:0] gpCount,
  input  logic             dimEn,
  input  logic             expire,
  input  logic             pwmGate,
  output tmrStrb_t         strb,
  output logic [CNT_W-1:0] loadVal,
  output logic             dimActive,
  output logic [1:0]       ledLevel,
  output logic             voltReg,
  output logic             convOn,
  output logic             timeoutPulse,
  output logic             swStartClr,
  output logic             modeClr,
  output logic             toFlag,
  output logic             overTemp
);
  opMode_e effMode;
  ledLvl_e lvl;
  logic strobePrev, swPrev, running, runGp;
  logic strobeRise, swRise, trigHigh, inFlash, inVolt;
  logic startFlash, startGp, abortRun, flashOn, expireHit;

  assign effMode    = thermFault ? MODE_SHUT : opMode_e'(modeSel);
  assign inFlash    = (effMode == MODE_FLASH);
  assign inVolt     = (effMode == MODE_VOLT);
  assign strobeRise = strobeIn && !strobePrev;
  assign swRise     = swStart && !swPrev;
  assign trigHigh   = strobeIn || swStart;

  assign startFlash = !running && inFlash && (strobeRise || swRise);
  assign startGp    = !running && inVolt && swRise;
  assign abortRun   = running &&
                      ((runGp ? !inVolt : !inFlash) ||
                       (!runGp && !edgeMode && !trigHigh));

  assign strb.load = startFlash || startGp;
  assign strb.run  = running && !abortRun;
  assign loadVal   = startGp ? gpCount : safetyCount;
  assign expireHit = strb.run && expire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrev   <= 1'b0;
      swPrev       <= 1'b0;
      running      <= 1'b0;
      runGp        <= 1'b0;
      timeoutPulse <= 1'b0;
      toFlag       <= 1'b0;
      overTemp     <= 1'b0;
    end else begin
      strobePrev   <= strobeIn;
      swPrev       <= swStart;
      timeoutPulse <= expireHit;
      if (abortRun || expireHit) running <= 1'b0;
      else if (strb.load) begin
        running <= 1'b1;
        runGp   <= startGp;
      end
      if (expireHit && runGp) toFlag <= 1'b1;
      else if (statusRead)    toFlag <= 1'b0;
      if (thermFault)         overTemp <= 1'b1;
      else if (statusRead)    overTemp <= 1'b0;
    end
  end

  assign swStartClr = timeoutPulse;
  assign modeClr    = thermFault;
  assign dimActive  = (effMode == MODE_TORCH) && dimEn;
  assign flashOn    = running && !runGp && inFlash && (edgeMode || trigHigh) && !maskIn;

  always_comb begin
    unique case (effMode)
      MODE_TORCH: lvl = (dimActive && !pwmGate) ? LVL_OFF : LVL_TORCH;
      MODE_FLASH: lvl = flashOn ? LVL_FLASH : LVL_TORCH;
      default:    lvl = LVL_OFF;
    endcase
  end

  assign ledLevel = lvl;
  assign voltReg  = !thermFault && (hwVoltMode || inVolt);
  assign convOn   = !thermFault && (hwVoltMode || effMode != MODE_SHUT);

  assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    thermFault |-> (ledLevel == LVL_OFF && !convOn && modeClr));

  assert_fault_sets_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    thermFault |=> overTemp);

  assert_mask_no_flash_R8: assert property (@(posedge clk) disable iff (!rstN)
    maskIn |-> (ledLevel != LVL_FLASH));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  assert_torch_no_timeout_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_TORCH && !thermFault) |=> !timeoutPulse);

  assert_level_needs_trig_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ledLevel == LVL_FLASH && !edgeMode) |-> (strobeIn || swStart));
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
  import flash_mode_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int PWM_PERIOD = 409836
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             hwVoltMode,
  input  logic             strobeIn,
  input  logic             swStart,
  input  logic             edgeMode,
  input  logic             maskIn,
  input  logic             thermFault,
  input  logic             statusRead,
  input  logic [CNT_W-1:0] safetyCount,
  input  logic [CNT_W-1:0] gpCount,
  input  logic             dimEn,
  input  logic [2:0]       dimDuty,
  output logic [1:0]       ledLevel,
  output logic             voltReg,
  output logic             convOn,
  output logic             timeoutPulse,
  output logic             swStartClr,
  output logic             modeClr,
  output logic             toFlag,
  output logic             overTemp
);
  tmrStrb_t         strb;
  logic [CNT_W-1:0] loadVal;
  logic             dimActive, expire, pwmGate;

  flash_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .hwVoltMode(hwVoltMode),
    .strobeIn(strobeIn), .swStart(swStart), .edgeMode(edgeMode),
    .maskIn(maskIn), .thermFault(thermFault), .statusRead(statusRead),
    .safetyCount(safetyCount), .gpCount(gpCount), .dimEn(dimEn),
    .expire(expire), .pwmGate(pwmGate), .strb(strb), .loadVal(loadVal),
    .dimActive(dimActive), .ledLevel(ledLevel), .voltReg(voltReg),
    .convOn(convOn), .timeoutPulse(timeoutPulse), .swStartClr(swStartClr),
    .modeClr(modeClr), .toFlag(toFlag), .overTemp(overTemp)
  );

  flash_mode_dp #(.TICK_DIV(TICK_DIV), .PWM_PERIOD(PWM_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .dimActive(dimActive), .dimDuty(dimDuty), .expire(expire),
    .pwmGate(pwmGate)
  );
endmodule

// File: tb/flash_mode_ctl_bench.sv
module flash_mode_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int PPER = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic hwVoltMode = 0, strobeIn = 0, swStart = 0, edgeMode = 0, maskIn = 0;
  logic thermFault = 0, statusRead = 0, dimEn = 0;
  logic [3:0] safetyCount = 4'd2, gpCount = 4'd1;
  logic [2:0] dimDuty = 3'd0;
  logic [1:0] ledLevel;
  logic voltReg, convOn, timeoutPulse, swStartClr, modeClr, toFlag, overTemp;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_mode_ctl #(.TICK_DIV(TDIV), .PWM_PERIOD(PPER)) u_flash_mode_ctl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .hwVoltMode(hwVoltMode),
    .strobeIn(strobeIn), .swStart(swStart), .edgeMode(edgeMode),
    .maskIn(maskIn), .thermFault(thermFault), .statusRead(statusRead),
    .safetyCount(safetyCount), .gpCount(gpCount), .dimEn(dimEn),
    .dimDuty(dimDuty), .ledLevel(ledLevel), .voltReg(voltReg),
    .convOn(convOn), .timeoutPulse(timeoutPulse), .swStartClr(swStartClr),
    .modeClr(modeClr), .toFlag(toFlag), .overTemp(overTemp)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {mode, hwVoltMode, expected level, expected voltReg, expected convOn}
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'd1, 1'b0, 2'd1, 1'b0, 1'b1},
    {2'd2, 1'b0, 2'd1, 1'b0, 1'b1},
    {2'd3, 1'b0, 2'd0, 1'b1, 1'b1},
    {2'd0, 1'b1, 2'd0, 1'b1, 1'b1},
    {2'd1, 1'b1, 2'd1, 1'b1, 1'b1},
    {2'd2, 1'b1, 2'd1, 1'b1, 1'b1},
    {2'd3, 1'b1, 2'd0, 1'b1, 1'b1}
  };

  initial begin
    int flashLen;
    flashLen = (2 + 1) * TDIV;
    #1;
    // R1: reset values
    chk("R1 level", ledLevel, 0);
    chk("R1 flags", {convOn, voltReg, timeoutPulse, swStartClr, toFlag, overTemp}, 0);
    idle(2);
    rstN = 1'b1;
    idle(2);

    // R2 / R11: mode decode table
    foreach (VEC[i]) begin
      @(negedge clk);
      modeSel = VEC[i][6:5];
      hwVoltMode = VEC[i][4];
      idle(2);
      chk(VEC[i][4] ? "R11 level" : "R2 level", ledLevel, VEC[i][3:2]);
      chk(VEC[i][4] ? "R11 voltReg" : "R2 voltReg", voltReg, VEC[i][1]);
      chk(VEC[i][4] ? "R11 convOn" : "R2 convOn", convOn, VEC[i][0]);
    end
    hwVoltMode = 0;

    // R3 / R5: level-triggered flash held until timeout
    modeSel = 2'd2; edgeMode = 0; idle(2);
    strobeIn = 1;
    for (int j = 0; j < flashLen; j++) begin
      @(negedge clk);
      chk("R3 flash while trigger high", ledLevel, 2);
      chk("R5 no early pulse", timeoutPulse, 0);
    end
    @(negedge clk);
    chk("R5 torch after timeout", ledLevel, 1);
    chk("R5 timeout pulse", timeoutPulse, 1);
    chk("R5 swStart clear", swStartClr, 1);
    @(negedge clk);
    chk("R5 pulse single", timeoutPulse, 0);
    strobeIn = 0; idle(3);

    // R4: level mode stops when trigger falls
    swStart = 1;
    idle(5);
    chk("R4 flash before fall", ledLevel, 2);
    swStart = 0; #1;
    chk("R4 torch at fall", ledLevel, 1);
    begin
      int seen = 0;
      for (int j = 0; j < flashLen + 4; j++) begin
        @(negedge clk);
        seen += timeoutPulse;
      end
      chk("R4 no timeout", seen, 0);
    end

    // R6: edge mode runs full length, ignores retrigger
    edgeMode = 1; idle(2);
    swStart = 1;
    for (int j = 0; j < flashLen; j++) begin
      @(negedge clk);
      if (j == 2) swStart = 0;
      if (j == 5) strobeIn = 1;
      if (j == 7) strobeIn = 0;
      if (j == 4 || j == flashLen - 1) chk("R6 flash continues", ledLevel, 2);
    end
    @(negedge clk);
    chk("R6 timeout unshifted", timeoutPulse, 1);
    chk("R6 back to torch", ledLevel, 1);
    idle(3);

    // R8: masking forces torch, timer unaffected
    strobeIn = 1;
    for (int j = 0; j < flashLen; j++) begin
      @(negedge clk);
      if (j == 3) begin maskIn = 1; #1; chk("R8 masked torch", ledLevel, 1); end
      if (j == 6) begin maskIn = 0; #1; chk("R8 flash resumes", ledLevel, 2); end
    end
    @(negedge clk);
    chk("R8 timeout same cycle", timeoutPulse, 1);
    strobeIn = 0; idle(3);

    // R12: torch mode ignores triggers
    modeSel = 2'd1; idle(2);
    strobeIn = 1; swStart = 1;
    begin
      int seen = 0;
      int notTorch = 0;
      for (int j = 0; j < flashLen + 4; j++) begin
        @(negedge clk);
        seen += timeoutPulse;
        notTorch += (ledLevel != 2'd1);
      end
      chk("R12 no timeout", seen, 0);
      chk("R12 torch held", notTorch, 0);
    end
    strobeIn = 0; swStart = 0; idle(2);

    // R7: general-purpose timer in mode 3
    modeSel = 2'd3; idle(2);
    swStart = 1;
    for (int j = 0; j < 2 * TDIV; j++) @(negedge clk);
    chk("R7 flag not yet", toFlag, 0);
    @(negedge clk);
    chk("R7 pulse", timeoutPulse, 1);
    chk("R7 flag set", toFlag, 1);
    swStart = 0; idle(3);
    chk("R7 flag sticky", toFlag, 1);
    statusRead = 1; @(negedge clk); statusRead = 0;
    chk("R7 flag cleared", toFlag, 0);

    // R9: thermal fault during a flash
    modeSel = 2'd2; edgeMode = 1; idle(2);
    strobeIn = 1; idle(3);
    thermFault = 1; #1;
    chk("R9 level off", ledLevel, 0);
    chk("R9 conv off", convOn, 0);
    chk("R9 mode clear", modeClr, 1);
    @(negedge clk);
    chk("R9 flag set", overTemp, 1);
    statusRead = 1; @(negedge clk); statusRead = 0;
    chk("R9 read ignored during fault", overTemp, 1);
    thermFault = 0; strobeIn = 0; modeSel = 2'd0;
    idle(flashLen + 2);
    chk("R9 flag sticky", overTemp, 1);
    chk("R9 no timeout after abort", timeoutPulse, 0);
    statusRead = 1; @(negedge clk); statusRead = 0;
    chk("R9 flag cleared", overTemp, 0);

    // R10: PWM dimming, duty 2 gives 6 of 16 cycles on
    modeSel = 2'd1; dimDuty = 3'd2; idle(2);
    dimEn = 1; #1;
    chk("R10 frame start torch", ledLevel, 1);
    begin
      int bad = 0;
      for (int j = 1; j <= PPER; j++) begin
        @(negedge clk);
        bad += (ledLevel != ((j % PPER) < 6 ? 2'd1 : 2'd0));
      end
      chk("R10 on/off pattern", bad, 0);
    end
    dimDuty = 3'd7;
    begin
      int off = 0;
      for (int j = 0; j < PPER; j++) begin
        @(negedge clk);
        off += (ledLevel == 2'd0);
      end
      chk("R10 full duty never off", off, 0);
    end
    dimEn = 0; modeSel = 2'd2; dimDuty = 3'd0; #1;
    chk("R10 no dimming outside torch", ledLevel, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule